// File: doc/BRIEF.md
# PHY Presence and Link Monitor

This block watches the results of completed serial management frames and keeps two 32-bit bitmaps, one bit for each possible PHY address. The presence bitmap shows whether the latest frame to an address was acknowledged. The link bitmap shows whether the last completed read of an address's basic status register reported link up. Frame generation is not part of this block. A frame engine reports each finished frame through a one-cycle completion strobe that carries the PHY address, the register address, the direction, the acknowledge flag and the read data.

Two monitor channels each follow one chosen PHY address. A channel takes its link level either from the link bitmap or from its own external link pin. The pin is first passed through a two-flop synchroniser. Each channel contains a small state machine with three states. MON_RESYNC tracks nothing yet. MON_DOWN holds a tracked level of 0 and MON_UP holds a tracked level of 1. The transitions are:
- MON_RESYNC to MON_DOWN or MON_UP: the channel takes the current source level, and no event is raised.
- MON_DOWN to MON_UP (link rise) and MON_UP to MON_DOWN (link fall): each sets the channel's raw change bit.
- Any state to MON_RESYNC: happens on a write to the channel's settings, so that switching the address or the source does not raise a false event.

The raw change bits are gated by the per-channel enables to form the masked bits. Their OR drives the interrupt line.

Top module: `phy_link_monitor`

## Requirements
- R1: On each completion strobe, presence bit [done_phy] becomes done_ack. This applies to reads and writes alike, and to every register address.
- R2: A presence-clear write clears every presence bit whose mask bit is 1 and leaves the bits whose mask bit is 0 unchanged. If a completion strobe hits the same address in the same cycle, the frame result wins.
- R3: A link bit changes only on a completed read (done_write = 0) of register address 1. The bit then becomes done_ack AND done_rdata[2]. Writes, and reads of other registers, leave the link bitmap unchanged.
- R4: A settings write with cfg_idx = k loads channel k's 5-bit monitored address, its interrupt enable and its source select. Source select 0 uses link[address]. Source select 1 uses link_pin[k] after two flops, so a pin edge reaches the raw bit on the third clock edge.
- R5: After a reset or a settings write, a channel first takes its source level without an event (MON_RESYNC). From then on, each change of the source level sets raw bit k one clock edge after the source changes.
- R6: A change-bit write with chg_wdata[k] = 1 and test_mode = 0 clears raw bit k. A 0 in chg_wdata[k] has no effect. A change event in the same cycle wins over the clear.
- R7: With test_mode = 1, a change-bit write with chg_wdata[k] = 1 sets raw bit k.
- R8: chg_masked[k] equals chg_raw[k] AND channel k's interrupt enable. irq is the OR of both masked bits.
- R9: After reset, both bitmaps, both raw bits, both masked bits and irq are 0. Both channels are set to address 0, interrupts disabled and bitmap source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_valid | input | 1 | One-cycle frame completion strobe |
| done_write | input | 1 | Completed frame was a register write |
| done_phy | input | 5 | PHY address of the completed frame |
| done_reg | input | 5 | Register address of the completed frame |
| done_ack | input | 1 | PHY acknowledged the frame |
| done_rdata | input | 16 | Read data of the completed frame |
| link_pin | input | 2 | Asynchronous external link levels, one for each channel |
| cfg_we | input | 1 | Channel settings write strobe |
| cfg_idx | input | 1 | Channel selected by the settings write |
| cfg_phy | input | 5 | Monitored PHY address to load |
| cfg_int_en | input | 1 | Interrupt enable to load |
| cfg_pin_sel | input | 1 | Source select to load (1 = external pin) |
| alive_clr_we | input | 1 | Presence-clear write strobe |
| alive_clr_mask | input | 32 | Presence bits to clear |
| chg_we | input | 1 | Change-bit write strobe |
| chg_wdata | input | 2 | Change-bit write data, one bit for each channel |
| test_mode | input | 1 | Interrupt test mode: change-bit writes set instead of clear |
| alive | output | 32 | PHY presence bitmap |
| link | output | 32 | PHY link bitmap |
| chg_raw | output | 2 | Raw link-change bits |
| chg_masked | output | 2 | Enabled link-change bits |
| irq | output | 1 | Link-change interrupt |

## Verification
The bench goes after three edge cases. The first is a presence clear that lands on the same address as a completion, where a design with the wrong priority would lose the new acknowledge. The second is a non-acknowledged status read, which must pull a link bit down even when the read data shows link up. The third is a write frame, or a read of another register, carrying link-up data: a design that decodes too loosely would set link bits from it. The bench also reconfigures channels on the fly, so a design that counts a source switch as a change would raise false interrupts. It steps an external pin and checks that the event arrives on exactly the third clock edge, which catches a missing or extra synchroniser stage. It also mixes change events with clear writes in the same cycle and with test-mode writes, where a wrong ordering would silently drop an event.

// File: rtl/plm_pkg.sv
package plm_pkg;
    localparam int NUM_PHY    = 32;
    localparam int PHY_AW     = 5;
    localparam int REG_AW     = 5;
    localparam int DATA_W     = 16;
    localparam int NUM_MON    = 2;
    localparam int STATUS_REG = 1;
    localparam int LINK_BIT   = 2;

    typedef enum logic [1:0] {
        MON_RESYNC = 2'd0,
        MON_DOWN   = 2'd1,
        MON_UP     = 2'd2
    } mon_state_e;

    typedef struct packed {
        logic [PHY_AW-1:0] phy;
        logic              int_en;
        logic              pin_sel;
    } mon_cfg_t;
endpackage

// File: rtl/plm_sync2.sv
module plm_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/plm_bitmap.sv
module plm_bitmap
    import plm_pkg::*;
#(
    parameter int N_PHY  = NUM_PHY,
    parameter int AW     = PHY_AW,
    parameter int RW     = REG_AW,
    parameter int DW     = DATA_W,
    parameter int ST_REG = STATUS_REG,
    parameter int LB     = LINK_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_valid,
    input  logic          done_write,
    input  logic [AW-1:0] done_phy,
    input  logic [RW-1:0] done_reg,
    input  logic          done_ack,
    input  logic [DW-1:0] done_rdata,
    input  logic          clr_we,
    input  logic [N_PHY-1:0] clr_mask,
    output logic [N_PHY-1:0] alive_q,
    output logic [N_PHY-1:0] link_q
);
    logic [N_PHY-1:0] alive_nxt;
    logic [N_PHY-1:0] link_nxt;
    logic             status_read;

    assign status_read = done_valid && !done_write && (done_reg == RW'(ST_REG));

    always_comb begin
        alive_nxt = alive_q;
        if (clr_we) begin
            alive_nxt = alive_q & ~clr_mask;
        end
        if (done_valid) begin
            alive_nxt[done_phy] = done_ack;
        end
        link_nxt = link_q;
        if (status_read) begin
            link_nxt[done_phy] = done_ack & done_rdata[LB];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alive_q <= '0;
            link_q  <= '0;
        end else begin
            alive_q <= alive_nxt;
            link_q  <= link_nxt;
        end
    end
endmodule

// File: rtl/plm_monitor.sv
module plm_monitor
    import plm_pkg::*;
#(
    parameter int N_PHY = NUM_PHY,
    parameter int AW    = PHY_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_phy,
    input  logic             cfg_int_en,
    input  logic             cfg_pin_sel,
    input  logic [N_PHY-1:0] link_vec,
    input  logic             pin_level,
    input  logic             wr_we,
    input  logic             wr_bit,
    input  logic             test_mode,
    output logic             raw_q,
    output logic             masked
);
    mon_cfg_t   cfg_q;
    mon_state_e state_q, state_nxt;
    logic       src;
    logic       change;
    logic       raw_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MON_RESYNC;
            cfg_q   <= '0;
            raw_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            raw_q   <= raw_nxt;
            if (cfg_we) begin
                cfg_q.phy     <= cfg_phy;
                cfg_q.int_en  <= cfg_int_en;
                cfg_q.pin_sel <= cfg_pin_sel;
            end
        end
    end

    always_comb begin
        src       = cfg_q.pin_sel ? pin_level : link_vec[cfg_q.phy];
        state_nxt = state_q;
        change    = 1'b0;
        unique case (state_q)
            MON_RESYNC: state_nxt = src ? MON_UP : MON_DOWN;
            MON_DOWN: begin
                if (src) begin
                    state_nxt = MON_UP;
                    change    = 1'b1;
                end
            end
            MON_UP: begin
                if (!src) begin
                    state_nxt = MON_DOWN;
                    change    = 1'b1;
                end
            end
            default: state_nxt = MON_RESYNC;
        endcase
        if (cfg_we) begin
            state_nxt = MON_RESYNC;
        end
        raw_nxt = raw_q;
        if (wr_we && wr_bit) begin
            raw_nxt = test_mode;
        end
        if (change) begin
            raw_nxt = 1'b1;
        end
        masked = raw_q & cfg_q.int_en;
    end
endmodule

// File: rtl/phy_link_monitor.sv
module phy_link_monitor
    import plm_pkg::*;
#(
    parameter int N_PHY = NUM_PHY,
    parameter int AW    = PHY_AW,
    parameter int RW    = REG_AW,
    parameter int DW    = DATA_W,
    parameter int N_MON = NUM_MON,
    localparam int IW   = (N_MON > 1) ? $clog2(N_MON) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_valid,
    input  logic             done_write,
    input  logic [AW-1:0]    done_phy,
    input  logic [RW-1:0]    done_reg,
    input  logic             done_ack,
    input  logic [DW-1:0]    done_rdata,
    input  logic [N_MON-1:0] link_pin,
    input  logic             cfg_we,
    input  logic [IW-1:0]    cfg_idx,
    input  logic [AW-1:0]    cfg_phy,
    input  logic             cfg_int_en,
    input  logic             cfg_pin_sel,
    input  logic             alive_clr_we,
    input  logic [N_PHY-1:0] alive_clr_mask,
    input  logic             chg_we,
    input  logic [N_MON-1:0] chg_wdata,
    input  logic             test_mode,
    output logic [N_PHY-1:0] alive,
    output logic [N_PHY-1:0] link,
    output logic [N_MON-1:0] chg_raw,
    output logic [N_MON-1:0] chg_masked,
    output logic             irq
);
    logic [N_MON-1:0] pin_sync;

    plm_sync2 #(.W(N_MON)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (link_pin),
        .q     (pin_sync)
    );

    plm_bitmap #(
        .N_PHY (N_PHY),
        .AW    (AW),
        .RW    (RW),
        .DW    (DW)
    ) u_bitmap (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_valid (done_valid),
        .done_write (done_write),
        .done_phy   (done_phy),
        .done_reg   (done_reg),
        .done_ack   (done_ack),
        .done_rdata (done_rdata),
        .clr_we     (alive_clr_we),
        .clr_mask   (alive_clr_mask),
        .alive_q    (alive),
        .link_q     (link)
    );

    for (genvar k = 0; k < N_MON; k++) begin : g_mon
        plm_monitor #(
            .N_PHY (N_PHY),
            .AW    (AW)
        ) u_mon (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_we      (cfg_we && (cfg_idx == IW'(k))),
            .cfg_phy     (cfg_phy),
            .cfg_int_en  (cfg_int_en),
            .cfg_pin_sel (cfg_pin_sel),
            .link_vec    (link),
            .pin_level   (pin_sync[k]),
            .wr_we       (chg_we),
            .wr_bit      (chg_wdata[k]),
            .test_mode   (test_mode),
            .raw_q       (chg_raw[k]),
            .masked      (chg_masked[k])
        );
    end

    assign irq = |chg_masked;
endmodule

// File: rtl/phy_link_monitor_chk.sv
module phy_link_monitor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        done_valid,
    input logic        done_write,
    input logic [4:0]  done_phy,
    input logic [4:0]  done_reg,
    input logic        done_ack,
    input logic        chg_we,
    input logic [31:0] alive,
    input logic [31:0] link,
    input logic [1:0]  chg_raw,
    input logic [1:0]  chg_masked,
    input logic        irq
);
    // R1 and R2: a completed frame always leaves its ack in the presence bit
    p_alive_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> alive[$past(done_phy)] == $past(done_ack));

    // R3: only a status-register read may move the link bitmap
    p_link_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_valid || done_write || done_reg != 5'd1) |=> $stable(link));

    // R6: a raw bit can only fall through a change-bit write
    p_raw0_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_raw[0] && !chg_we) |=> chg_raw[0]);
    p_raw1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_raw[1] && !chg_we) |=> chg_raw[1]);

    // R8: masked bits are a subset of raw bits, and any masked bit raises irq
    p_masked_sub_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_masked & ~chg_raw) == 2'b00);
    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_masked != 2'b00) |-> irq);
endmodule

bind phy_link_monitor phy_link_monitor_chk u_chk (.*);

// File: tb/phy_link_monitor_bench.sv
module phy_link_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_valid = 0, done_write = 0, done_ack = 0;
    logic [4:0]  done_phy = 0, done_reg = 0;
    logic [15:0] done_rdata = 0;
    logic [1:0]  link_pin = 0;
    logic        cfg_we = 0, cfg_idx = 0, cfg_int_en = 0, cfg_pin_sel = 0;
    logic [4:0]  cfg_phy = 0;
    logic        alive_clr_we = 0;
    logic [31:0] alive_clr_mask = 0;
    logic        chg_we = 0, test_mode = 0;
    logic [1:0]  chg_wdata = 0;
    logic [31:0] alive, link;
    logic [1:0]  chg_raw, chg_masked;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    phy_link_monitor u_phy_link_monitor (.*);

    // reference model built from the requirements
    logic [31:0] m_alive, m_link;
    logic [1:0]  m_s1, m_s2, m_raw, m_en, m_sel;
    logic [4:0]  m_phy [2];
    logic [1:0]  m_trk [2];   // 0 untracked, 1 down, 2 up

    always @(posedge clk) begin
        if (!rst_n) begin
            m_alive <= '0; m_link <= '0; m_s1 <= '0; m_s2 <= '0;
            m_raw <= '0; m_en <= '0; m_sel <= '0;
            for (int k = 0; k < 2; k++) begin
                m_phy[k] <= '0; m_trk[k] <= 2'd0;
            end
        end else begin
            automatic logic [31:0] a = m_alive;
            automatic logic [31:0] l = m_link;
            if (alive_clr_we) a = a & ~alive_clr_mask;
            if (done_valid) a[done_phy] = done_ack;
            if (done_valid && !done_write && done_reg == 5'd1)
                l[done_phy] = done_ack & done_rdata[2];
            m_alive <= a;
            m_link  <= l;
            m_s1 <= link_pin;
            m_s2 <= m_s1;
            for (int k = 0; k < 2; k++) begin
                automatic logic src = m_sel[k] ? m_s2[k] : m_link[m_phy[k]];
                automatic logic ev = 1'b0;
                automatic logic [1:0] nt = src ? 2'd2 : 2'd1;
                automatic logic r = m_raw[k];
                if (m_trk[k] != 2'd0 && m_trk[k] != nt) ev = 1'b1;
                if (cfg_we && cfg_idx == k[0]) begin
                    nt = 2'd0;
                    m_phy[k] <= cfg_phy; m_en[k] <= cfg_int_en; m_sel[k] <= cfg_pin_sel;
                end
                m_trk[k] <= nt;
                if (chg_we && chg_wdata[k]) r = test_mode;
                if (ev) r = 1'b1;
                m_raw[k] <= r;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_model();
        chk("R1/R2 alive", alive, m_alive);
        chk("R3 link", link, m_link);
        chk("R5/R6/R7 chg_raw", {30'd0, chg_raw}, {30'd0, m_raw});
        chk("R8 chg_masked", {30'd0, chg_masked}, {30'd0, m_raw & m_en});
        chk("R8 irq", {31'd0, irq}, {31'd0, |(m_raw & m_en)});
    endtask

    task automatic idle();
        done_valid = 0; cfg_we = 0; alive_clr_we = 0; chg_we = 0;
    endtask

    task automatic frame(input logic wr, input logic [4:0] p, input logic [4:0] r,
                         input logic ack, input logic [15:0] d);
        done_valid = 1; done_write = wr; done_phy = p; done_reg = r;
        done_ack = ack; done_rdata = d;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk("R9 alive", alive, 0);
        chk("R9 link", link, 0);
        chk("R9 irq/raw", {29'd0, irq, chg_raw}, 0);

        // R1 R3 ack status read with link up
        frame(0, 5'd5, 5'd1, 1, 16'h0004);
        @(negedge clk); idle();
        chk("R1 alive ack", alive, 32'h20);
        chk("R3 link up", link, 32'h20);
        // R3 write frame carrying link data does not touch link, R1 nack clears alive
        frame(1, 5'd5, 5'd1, 0, 16'h0000);
        @(negedge clk); idle();
        chk("R1 alive nack", alive, 32'h0);
        chk("R3 write ignored", link, 32'h20);
        // R3 nacked status read clears link even with bit 2 set
        frame(0, 5'd5, 5'd1, 0, 16'hFFFF);
        @(negedge clk); idle();
        chk("R3 nack clears", link, 32'h0);
        // R2 clear vs same-cycle ack: frame wins; mask 0 bits untouched
        frame(0, 5'd7, 5'd3, 1, 16'h0);
        @(negedge clk);
        frame(0, 5'd9, 5'd3, 1, 16'h0);
        alive_clr_we = 1; alive_clr_mask = 32'h0000_0200;
        @(negedge clk); idle();
        chk("R2 frame wins over clear", alive, 32'h0000_0280);
        alive_clr_we = 1; alive_clr_mask = 32'h0000_0080;
        @(negedge clk); idle();
        chk("R2 clear one bit", alive, 32'h0000_0200);

        // R4 R5 pin source on channel 1 with interrupt enabled
        cfg_we = 1; cfg_idx = 1; cfg_phy = 5'd3; cfg_int_en = 1; cfg_pin_sel = 1;
        @(negedge clk); idle();
        repeat (3) @(negedge clk);
        chk("R5 resync no event", {30'd0, chg_raw}, 0);
        link_pin = 2'b10;
        @(negedge clk);
        @(negedge clk);
        chk("R4 sync latency", {30'd0, chg_raw}, 0);
        @(negedge clk);
        chk("R4 pin event", {30'd0, chg_raw}, 2);
        chk("R8 irq", {31'd0, irq}, 1);
        // R6 write 0 no effect, write 1 clears
        chg_we = 1; chg_wdata = 2'b01;
        @(negedge clk); idle();
        chk("R6 zero no effect", {30'd0, chg_raw}, 2);
        chg_we = 1; chg_wdata = 2'b10;
        @(negedge clk); idle();
        chk("R6 clear", {30'd0, chg_raw}, 0);
        // R7 test mode set on channel 0 (disabled), masked stays 0
        test_mode = 1; chg_we = 1; chg_wdata = 2'b01;
        @(negedge clk); idle(); test_mode = 0;
        chk("R7 test set", {30'd0, chg_raw}, 1);
        chk("R8 masked gated", {30'd0, chg_masked}, 0);

        // constrained random phase against the model
        for (int n = 0; n < 6000; n++) begin
            automatic int unsigned pick;
            check_model();
            idle();
            if ($urandom_range(99) < 50) begin
                pick = $urandom_range(2);
                done_valid = 1;
                done_write = ($urandom_range(3) == 0);
                done_phy   = (pick == 0) ? m_phy[0] : (pick == 1) ? m_phy[1] : 5'($urandom);
                done_reg   = ($urandom_range(1) == 0) ? 5'd1 : 5'($urandom);
                done_ack   = ($urandom_range(4) != 0);
                done_rdata = 16'($urandom);
            end
            if ($urandom_range(99) < 5) link_pin = link_pin ^ 2'($urandom_range(1, 3));
            if ($urandom_range(99) < 3) begin
                cfg_we = 1; cfg_idx = 1'($urandom); cfg_phy = 5'($urandom_range(3));
                cfg_int_en = 1'($urandom); cfg_pin_sel = 1'($urandom);
            end
            if ($urandom_range(99) < 5) begin
                alive_clr_we = 1; alive_clr_mask = $urandom;
            end
            if ($urandom_range(99) < 6) begin
                chg_we = 1; chg_wdata = 2'($urandom);
            end
            test_mode = ($urandom_range(9) == 0);
            @(negedge clk);
        end
        check_model();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule